// File: doc/BRIEF.md
# ARINC 429 Receive Word Filter and Buffer

This block sits behind a bit-level ARINC 429 line receiver. Each time the receiver presents a complete 32-bit word with a one-cycle valid strobe, the block decides whether the word should be kept. Several gates decide this:

- a master receive enable;
- an optional odd-parity test over the whole word;
- an optional comparison of the two source/destination bits against configured values;
- an optional label-acceptance input, driven by an external label lookup.

Words that pass every gate are queued in a first-in first-out buffer for the host to collect.

The host reads through a show-ahead port: the oldest stored word is always visible on the read data output, and a read strobe removes it. The block reports four conditions: the buffer is empty, at least half full, or full, plus one sticky indication that a qualifying word was lost because the buffer was full. A single flag output can be switched to mirror either the empty or the full condition. All configuration arrives as plain control inputs.

Top module: `arx_filter_fifo`

## Requirements
- R1: While `cfg_rx_en` is 0, a word presented on `in_valid` is never stored, whatever the other inputs are.
- R2: While `cfg_par_en` is 1, only words whose 32 bits contain an odd number of ones are stored. While it is 0, parity does not affect storage.
- R3: While `cfg_dec_en` is 1, a word is stored only if `in_word[9]` (line bit 10) equals `cfg_dec_b10` and `in_word[8]` (line bit 9) equals `cfg_dec_b9`. Line bit n is carried on `in_word[n-1]`.
- R4: While `cfg_lbl_en` is 1, a word is stored only if `in_lbl_ok` is 1 in the same cycle as `in_valid`.
- R5: `st_empty` is 1 after reset and whenever no word is stored. It returns to 1 after the last stored word is read.
- R6: `st_half` is 1 exactly when 16 or more words are stored.
- R7: `st_full` is 1 exactly when 32 words are stored. The buffer holds 32 words of 32 bits.
- R8: `flag` equals `st_empty` while `cfg_flag_sel` is 0, and equals `st_full` while it is 1.
- R9: A read of a non-empty buffer and a qualifying write in the same cycle are both carried out, and the stored count stays the same. This holds even when the buffer is full.
- R10: `rd_data` shows the oldest stored word, and words leave in arrival order. A read strobe while the buffer is empty has no effect.
- R11: A qualifying word that arrives while the buffer is full, with no read in the same cycle, is dropped. The stored contents are kept, and `st_ovf` rises to 1. `st_ovf` stays at 1 until the next read of a stored word clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe: a received word is present |
| in_word | input | 32 | Received word; line bit n is on bit n-1 |
| in_lbl_ok | input | 1 | Label lookup accepts the present word |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_par_en | input | 1 | Odd-parity check enable |
| cfg_lbl_en | input | 1 | Label acceptance gating enable |
| cfg_dec_en | input | 1 | Source/destination bit match enable |
| cfg_dec_b10 | input | 1 | Required value of line bit 10 |
| cfg_dec_b9 | input | 1 | Required value of line bit 9 |
| cfg_flag_sel | input | 1 | Flag source: 0 empty, 1 full |
| rd_en | input | 1 | Read strobe: remove the oldest word |
| rd_data | output | 32 | Oldest stored word (show-ahead) |
| st_empty | output | 1 | Buffer holds no word |
| st_half | output | 1 | Buffer holds 16 or more words |
| st_full | output | 1 | Buffer holds 32 words |
| st_ovf | output | 1 | Sticky: a qualifying word was dropped |
| flag | output | 1 | Selected status |

## Verification
Stores, reads and the overflow indication all take effect at the clock edge that samples the strobe. The status outputs and `rd_data` follow combinationally from the updated state, so every result is due one edge after its stimulus. The bench drives inputs on the falling edge and keeps a queue-based model that it advances on the rising edge. On each following falling edge it compares every output with the model, so each comparison looks exactly one register stage past the stimulus. Directed phases walk through each gate and through the half, full and overflow boundaries, and a random phase then mixes all inputs.

// File: rtl/arx_pkg.sv
package arx_pkg;
   localparam int unsigned ARX_WORD_W = 32;
   localparam int unsigned ARX_B10_POS = 9;
   localparam int unsigned ARX_B9_POS = 8;

   typedef struct packed {
      logic rx_en;
      logic par_en;
      logic lbl_en;
      logic dec_en;
      logic dec_b10;
      logic dec_b9;
   } arx_gate_cfg_t;
endpackage

// File: rtl/arx_word_gate.sv
module arx_word_gate
   import arx_pkg::*;
#(
   parameter int unsigned WORD_W = ARX_WORD_W,
   parameter bit          ODD_PARITY = 1'b1
) (
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   input  logic              in_lbl_ok,
   input  arx_gate_cfg_t     cfg,
   output logic              keep
);
   if (WORD_W <= ARX_B10_POS) begin : g_bad_width
      $error("arx_word_gate: WORD_W too small for the bit 10/9 match");
   end

   logic par_ok;
   logic dec_ok;
   logic lbl_ok;

   if (ODD_PARITY) begin : g_par_odd
      assign par_ok = ^in_word;
   end else begin : g_par_even
      assign par_ok = ~^in_word;
   end

   always_comb begin
      dec_ok = (in_word[ARX_B10_POS] == cfg.dec_b10) &&
               (in_word[ARX_B9_POS] == cfg.dec_b9);
      lbl_ok = in_lbl_ok;
      keep   = in_valid && cfg.rx_en &&
               (!cfg.par_en || par_ok) &&
               (!cfg.dec_en || dec_ok) &&
               (!cfg.lbl_en || lbl_ok);
   end
endmodule

// File: rtl/arx_word_fifo.sv
module arx_word_fifo #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned DEPTH  = 32,
   localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_req,
   output logic [WORD_W-1:0] rd_data,
   output logic [CW-1:0]     count,
   output logic              push,
   output logic              pop
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("arx_word_fifo: DEPTH must be at least 2");
   end

   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wptr, rptr, wptr_nx, rptr_nx;
   logic              is_full, is_empty;

   always_comb begin
      is_full  = (count == FULL_CNT);
      is_empty = (count == '0);
      pop      = rd_req && !is_empty;
      push     = wr_req && (!is_full || pop);
   end

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      always_comb begin
         wptr_nx = wptr + AW'(1);
         rptr_nx = rptr + AW'(1);
      end
   end else begin : g_wrap_cmp
      always_comb begin
         wptr_nx = (wptr == LAST_IDX) ? '0 : wptr + AW'(1);
         rptr_nx = (rptr == LAST_IDX) ? '0 : rptr + AW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= wptr_nx;
         if (pop)  rptr <= rptr_nx;
         if (push && !pop)      count <= count + CW'(1);
         else if (pop && !push) count <= count - CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= wr_data;
   end

   assign rd_data = mem[rptr];
endmodule

// File: rtl/arx_fifo_status.sv
module arx_fifo_status #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned HALF_MARK = DEPTH / 2,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count,
   input  logic          keep,
   input  logic          pop,
   input  logic          flag_sel,
   output logic          empty,
   output logic          half,
   output logic          full,
   output logic          ovf,
   output logic          flag
);
   if (HALF_MARK == 0 || HALF_MARK > DEPTH) begin : g_bad_mark
      $error("arx_fifo_status: HALF_MARK out of range");
   end

   always_comb begin
      empty = (count == '0);
      half  = (count >= CW'(HALF_MARK));
      full  = (count == CW'(DEPTH));
      flag  = flag_sel ? full : empty;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf <= 1'b0;
      end else if (pop) begin
         ovf <= 1'b0;
      end else if (keep && full) begin
         ovf <= 1'b1;
      end
   end
endmodule

// File: rtl/arx_filter_fifo.sv
module arx_filter_fifo
   import arx_pkg::*;
#(
   parameter int unsigned WORD_W    = ARX_WORD_W,
   parameter int unsigned DEPTH     = 32,
   parameter int unsigned HALF_MARK = 16,
   parameter bit          ODD_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   input  logic              in_lbl_ok,
   input  logic              cfg_rx_en,
   input  logic              cfg_par_en,
   input  logic              cfg_lbl_en,
   input  logic              cfg_dec_en,
   input  logic              cfg_dec_b10,
   input  logic              cfg_dec_b9,
   input  logic              cfg_flag_sel,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   output logic              st_empty,
   output logic              st_half,
   output logic              st_full,
   output logic              st_ovf,
   output logic              flag
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   arx_gate_cfg_t     gcfg;
   logic              keep, push, pop;
   logic [CW-1:0]     count;

   assign gcfg = '{rx_en: cfg_rx_en, par_en: cfg_par_en, lbl_en: cfg_lbl_en,
                   dec_en: cfg_dec_en, dec_b10: cfg_dec_b10, dec_b9: cfg_dec_b9};

   arx_word_gate #(.WORD_W(WORD_W), .ODD_PARITY(ODD_PARITY)) u_gate (
      .in_valid (in_valid),
      .in_word  (in_word),
      .in_lbl_ok(in_lbl_ok),
      .cfg      (gcfg),
      .keep     (keep)
   );

   arx_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_req (keep),
      .wr_data(in_word),
      .rd_req (rd_en),
      .rd_data(rd_data),
      .count  (count),
      .push   (push),
      .pop    (pop)
   );

   arx_fifo_status #(.DEPTH(DEPTH), .HALF_MARK(HALF_MARK)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .count   (count),
      .keep    (keep),
      .pop     (pop),
      .flag_sel(cfg_flag_sel),
      .empty   (st_empty),
      .half    (st_half),
      .full    (st_full),
      .ovf     (st_ovf),
      .flag    (flag)
   );

   AST_DISABLED_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cfg_rx_en && !rd_en) |=> $stable(count)); // R1
   AST_BAD_PARITY_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cfg_par_en && !(^in_word) && !rd_en) |=> $stable(count)); // R2
   AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_empty && st_full)); // R7
   AST_EMPTY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_empty) |-> $past(rd_en)); // R5
   AST_RW_SAME_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !st_empty && keep) |=> $stable(count)); // R9
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_ovf && !rd_en) |=> st_ovf); // R11
   AST_FULL_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (st_full && !rd_en) |=> $stable(rd_data)); // R11
endmodule

// File: tb/tb_arx_filter_fifo.sv
module tb_arx_filter_fifo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = '0;
   logic        in_lbl_ok = 1'b0;
   logic        cfg_rx_en = 1'b0, cfg_par_en = 1'b0, cfg_lbl_en = 1'b0;
   logic        cfg_dec_en = 1'b0, cfg_dec_b10 = 1'b0, cfg_dec_b9 = 1'b0;
   logic        cfg_flag_sel = 1'b0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        st_empty, st_half, st_full, st_ovf, flag;

   int n_tests = 0;
   int n_fail  = 0;

   logic [31:0] q[$];
   bit          m_ovf = 0;

   always #2.5 clk = ~clk;

   arx_filter_fifo dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .in_lbl_ok(in_lbl_ok), .cfg_rx_en(cfg_rx_en), .cfg_par_en(cfg_par_en),
      .cfg_lbl_en(cfg_lbl_en), .cfg_dec_en(cfg_dec_en), .cfg_dec_b10(cfg_dec_b10),
      .cfg_dec_b9(cfg_dec_b9), .cfg_flag_sel(cfg_flag_sel), .rd_en(rd_en),
      .rd_data(rd_data), .st_empty(st_empty), .st_half(st_half),
      .st_full(st_full), .st_ovf(st_ovf), .flag(flag)
   );

   function automatic bit m_accept();
      bit ok;
      ok = in_valid && cfg_rx_en;
      if (cfg_par_en && ($countones(in_word) % 2 == 0)) ok = 0;
      if (cfg_dec_en && (in_word[9] != cfg_dec_b10 || in_word[8] != cfg_dec_b9)) ok = 0;
      if (cfg_lbl_en && !in_lbl_ok) ok = 0;
      return ok;
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         bit acc, rd, was_full;
         acc = m_accept();
         rd = rd_en && (q.size() > 0);
         was_full = (q.size() == 32);
         if (rd) void'(q.pop_front());
         if (acc && (!was_full || rd)) q.push_back(in_word);
         if (rd) m_ovf = 0;
         else if (acc && was_full) m_ovf = 1;
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R5 empty", 32'(st_empty), 32'(q.size() == 0));
      chk("R6 half", 32'(st_half), 32'(q.size() >= 16));
      chk("R7 full", 32'(st_full), 32'(q.size() == 32));
      chk("R8 flag", 32'(flag), 32'(cfg_flag_sel ? (q.size() == 32) : (q.size() == 0)));
      chk("R11 ovf", 32'(st_ovf), 32'(m_ovf));
      if (q.size() > 0) chk("R10 rd_data", rd_data, q[0]);
   endtask

   task automatic step(bit v, logic [31:0] w, bit lbl, bit rd);
      in_valid = v; in_word = w; in_lbl_ok = lbl; rd_en = rd;
      @(negedge clk);
      compare_all();
   endtask

   function automatic logic [31:0] mk(logic [30:0] body, bit odd);
      logic [31:0] w;
      w = {1'b0, body};
      if (($countones(w) % 2 == 1) != odd) w[31] = 1'b1;
      return w;
   endfunction

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int sz;
      repeat (3) @(negedge clk);
      chk("R5 reset empty", 32'(st_empty), 32'd1);
      chk("R11 reset ovf", 32'(st_ovf), 32'd0);
      rst_n = 1'b1;
      cfg_rx_en = 1'b1;
      @(negedge clk);

      // R10: order of stored words
      step(1, 32'h1111_0001, 0, 0);
      step(1, 32'h2222_0002, 0, 0);
      step(1, 32'h3333_0003, 0, 0);
      chk("R10 head", rd_data, 32'h1111_0001);
      step(0, 0, 0, 1);
      chk("R10 second", rd_data, 32'h2222_0002);
      step(0, 0, 0, 1);
      step(0, 0, 0, 1);
      chk("R5 empty after drain", 32'(st_empty), 32'd1);
      step(0, 0, 0, 1);
      chk("R10 read on empty", 32'(st_empty), 32'd1);

      // R1: receiver disabled
      cfg_rx_en = 1'b0;
      step(1, 32'hABCD_0001, 1, 0);
      chk("R1 disabled", 32'(st_empty), 32'd1);
      cfg_rx_en = 1'b1;

      // R2: parity gate
      cfg_par_en = 1'b1;
      step(1, mk(31'h0000_1234, 0), 0, 0);
      chk("R2 even dropped", 32'(st_empty), 32'd1);
      step(1, mk(31'h0000_1234, 1), 0, 0);
      chk("R2 odd stored", 32'(st_empty), 32'd0);
      step(0, 0, 0, 1);
      cfg_par_en = 1'b0;
      step(1, mk(31'h0000_0055, 0), 0, 0);
      chk("R2 off even stored", 32'(st_empty), 32'd0);
      step(0, 0, 0, 1);

      // R3: bit 10 / bit 9 match
      cfg_dec_en = 1'b1; cfg_dec_b10 = 1'b1; cfg_dec_b9 = 1'b0;
      step(1, 32'h0000_0100, 0, 0);
      chk("R3 mismatch dropped", 32'(st_empty), 32'd1);
      step(1, 32'h0000_0200, 0, 0);
      chk("R3 match stored", rd_data, 32'h0000_0200);
      step(0, 0, 0, 1);
      cfg_dec_en = 1'b0;

      // R4: label gate
      cfg_lbl_en = 1'b1;
      step(1, 32'h0000_00AA, 0, 0);
      chk("R4 label reject", 32'(st_empty), 32'd1);
      step(1, 32'h0000_00AB, 1, 0);
      chk("R4 label accept", rd_data, 32'h0000_00AB);
      step(0, 0, 0, 1);
      cfg_lbl_en = 1'b0;

      // R6 R7 R8 fill
      for (int i = 0; i < 16; i++) step(1, 32'h5000_0000 + i, 0, 0);
      chk("R6 half at 16", 32'(st_half), 32'd1);
      for (int i = 16; i < 32; i++) step(1, 32'h5000_0000 + i, 0, 0);
      chk("R7 full at 32", 32'(st_full), 32'd1);
      cfg_flag_sel = 1'b1;
      #1 chk("R8 flag shows full", 32'(flag), 32'd1);
      cfg_flag_sel = 1'b0;
      #1 chk("R8 flag shows empty", 32'(flag), 32'd0);

      // R11 overflow
      step(1, 32'hDEAD_BEEF, 0, 0);
      chk("R11 ovf set", 32'(st_ovf), 32'd1);
      chk("R11 head kept", rd_data, 32'h5000_0000);
      step(0, 0, 0, 0);
      chk("R11 ovf sticky", 32'(st_ovf), 32'd1);

      // R9 read and write while full
      step(1, 32'hCAFE_0001, 0, 1);
      chk("R9 count kept full", 32'(st_full), 32'd1);
      chk("R11 ovf cleared by read", 32'(st_ovf), 32'd0);
      chk("R9 head advanced", rd_data, 32'h5000_0001);
      for (int i = 0; i < 32; i++) step(0, 0, 0, 1);
      chk("R5 empty after full drain", 32'(st_empty), 32'd1);
      step(1, 32'h0BAD_F00D, 0, 1);
      chk("R9 write with read on empty", rd_data, 32'h0BAD_F00D);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         sz = q.size();
         cfg_par_en = ($urandom % 4) == 0;
         cfg_dec_en = ($urandom % 4) == 0;
         cfg_lbl_en = ($urandom % 4) == 0;
         cfg_rx_en  = ($urandom % 8) != 0;
         cfg_dec_b10 = $urandom; cfg_dec_b9 = $urandom;
         cfg_flag_sel = $urandom;
         step($urandom % 4 != 0, $urandom, $urandom,
              (sz > 20) ? ($urandom % 3 != 0) : ($urandom % 3 == 0));
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule